// File: doc/BRIEF.md
# Microprogram Sequencer with Control Decode

This block is the control unit of a microcoded processor. An 8-bit control address register (the sequencer's micro program counter) selects one 28-bit micro-word from a 256-entry control table held inside the block as computed constants. Each micro-word is split into its control fields, and those fields drive the datapath, the program counter logic and the memory interface of the processor.

On every clock edge the sequencer picks the next control address. A 3-bit condition select, taken from the current micro-word, tests the datapath status flags. When the condition holds, the address steps by one. Otherwise the address is loaded from one of two sources, chosen by a 1-bit load select: the micro-word's own next-address field, or the opcode of the instruction now held in the instruction register. An opcode is therefore the control address of the first micro-operation of its instruction.

All control outputs decode the registered address. The status flags reach only the step decision, so every control output changes only on a clock edge that moves the address.

Top module: `useq_ctrl`

## Requirements
- R1: An active-low asynchronous reset forces the control address `car_o` to 0 at once, without waiting for a clock edge.
- R2: The control word stored at address a is {a+37 mod 256 (8 bits), a[2:0] (3 bits), a[3] (1 bit), a[7:0], ~a[7:0]}, with the most significant bit first, 28 bits in all.
- R3: The outputs are slices of the word at `car_o`. The slices are: next_addr_o = [27:20], cond_sel_o = [19:17], load_sel_o = [16], ir_load_o = [15], pc_inc_o = [14], pc_load_o = [13], tmp_dst_o = [12], tmp_a_o = [11], tmp_b_o = [10], imm_sel_o = [9], fn_sel_o = [8:4], mem_data_sel_o = [3], reg_wr_o = [2], mem_addr_sel_o = [1], mem_wr_o = [0].
- R4: The condition select values have these meanings: 0 never true, 1 always true, 2 carry, 3 zero, 4 negative, 5 overflow, 6 not zero, 7 not carry. The flag bits are flags_i[0] = carry, [1] = zero, [2] = negative, [3] = overflow.
- R5: When the selected condition is true, `car_o` becomes `car_o`+1 (mod 256) on the next clock edge, whatever the load select.
- R6: When the condition is false and load_sel_o is 0, `car_o` loads next_addr_o on the next clock edge.
- R7: When the condition is false and load_sel_o is 1, `car_o` loads opcode_i zero-extended to 8 bits on the next clock edge.
- R8: No output changes while `car_o` holds its value. In particular, flags_i and opcode_i have no combinational effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| opcode_i | input | 7 | Opcode from the instruction register |
| flags_i | input | 4 | Status flags: carry, zero, negative, overflow |
| car_o | output | 8 | Current control address |
| next_addr_o | output | 8 | Next-address field of the micro-word |
| cond_sel_o | output | 3 | Condition select for the step decision |
| load_sel_o | output | 1 | Load source: 0 next-address field, 1 opcode |
| ir_load_o | output | 1 | Instruction register load |
| pc_inc_o | output | 1 | Program counter increment |
| pc_load_o | output | 1 | Program counter relative load |
| tmp_dst_o | output | 1 | Write the scratch register instead of the destination |
| tmp_a_o | output | 1 | Read the scratch register on port A |
| tmp_b_o | output | 1 | Read the scratch register on port B |
| imm_sel_o | output | 1 | Use the immediate operand on port B |
| fn_sel_o | output | 5 | Function unit operation select |
| mem_data_sel_o | output | 1 | Write back memory data instead of the function unit result |
| reg_wr_o | output | 1 | Register file write enable |
| mem_addr_sel_o | output | 1 | Address memory from the program counter |
| mem_wr_o | output | 1 | Memory write enable |

## Verification
The step decision and the opcode load can both be requested in the same cycle: a micro-word can have load_sel_o set while its condition evaluates true. The bench walks the sequencer to such a word and sets the flags so that the condition holds. It then checks that the address steps by one and does not jump to the opcode driven on opcode_i, which is chosen to differ from the stepped address. The opposite case, the same kind of word with the condition false, must load the full-range opcode zero-extended, and this is judged the same way.

// File: rtl/useq_pkg.sv
package useq_pkg;
  parameter int AW = 8;
  parameter int OPW = 7;
  parameter int MSW = 3;
  parameter int FSW = 5;
  parameter int FLGW = 4;
  parameter int NXT_STEP = 37;
  localparam int DEPTH = 1 << AW;
  localparam int CTLW = 2 * AW;
  localparam int UW = AW + MSW + 1 + CTLW;

  localparam int FLG_C = 0;
  localparam int FLG_Z = 1;
  localparam int FLG_N = 2;
  localparam int FLG_V = 3;

  typedef enum logic [MSW-1:0] {
    CND_NEVER, CND_ALWAYS, CND_C, CND_Z, CND_N, CND_V, CND_NZ, CND_NC
  } cond_e;

  typedef struct packed {
    logic [AW-1:0]  nxt;
    cond_e          ms;
    logic           mc;
    logic           il;
    logic           pi;
    logic           pl;
    logic           td;
    logic           ta;
    logic           tb;
    logic           mb;
    logic [FSW-1:0] fs;
    logic           md;
    logic           rw;
    logic           mm;
    logic           mw;
  } uword_t;

  function automatic uword_t ucode_word(input logic [AW-1:0] a);
    uword_t w;
    w.nxt = a + AW'(NXT_STEP);
    w.ms  = cond_e'(a[MSW-1:0]);
    w.mc  = a[MSW];
    {w.il, w.pi, w.pl, w.td, w.ta, w.tb, w.mb, w.fs, w.md, w.rw, w.mm, w.mw} = {a, ~a};
    return w;
  endfunction
endpackage

// File: rtl/useq_rom.sv
module useq_rom
  import useq_pkg::*;
(
  input  logic [AW-1:0] addr_i,
  output uword_t        word_o
);
  uword_t tbl [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_row
    assign tbl[g] = ucode_word(AW'(g));
  end

  assign word_o = tbl[addr_i];
endmodule

// File: rtl/useq_cond.sv
module useq_cond
  import useq_pkg::*;
(
  input  cond_e           sel_i,
  input  logic [FLGW-1:0] flags_i,
  output logic            inc_o
);
  always_comb begin
    unique case (sel_i)
      CND_NEVER:  inc_o = 1'b0;
      CND_ALWAYS: inc_o = 1'b1;
      CND_C:      inc_o = flags_i[FLG_C];
      CND_Z:      inc_o = flags_i[FLG_Z];
      CND_N:      inc_o = flags_i[FLG_N];
      CND_V:      inc_o = flags_i[FLG_V];
      CND_NZ:     inc_o = ~flags_i[FLG_Z];
      CND_NC:     inc_o = ~flags_i[FLG_C];
      default:    inc_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/useq_car.sv
module useq_car
  import useq_pkg::*;
(
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           inc_i,
  input  logic           load_sel_i,
  input  logic [AW-1:0]  nxt_i,
  input  logic [OPW-1:0] opcode_i,
  output logic [AW-1:0]  car_o
);
  logic [AW-1:0] car_d;

  // step has priority over either load source
  always_comb begin
    if (inc_i)           car_d = car_o + AW'(1);
    else if (load_sel_i) car_d = AW'(opcode_i);
    else                 car_d = nxt_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) car_o <= '0;
    else         car_o <= car_d;
  end
endmodule

// File: rtl/useq_ctrl.sv
module useq_ctrl
  import useq_pkg::*;
(
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [6:0]     opcode_i,
  input  logic [3:0]     flags_i,
  output logic [7:0]     car_o,
  output logic [7:0]     next_addr_o,
  output logic [2:0]     cond_sel_o,
  output logic           load_sel_o,
  output logic           ir_load_o,
  output logic           pc_inc_o,
  output logic           pc_load_o,
  output logic           tmp_dst_o,
  output logic           tmp_a_o,
  output logic           tmp_b_o,
  output logic           imm_sel_o,
  output logic [4:0]     fn_sel_o,
  output logic           mem_data_sel_o,
  output logic           reg_wr_o,
  output logic           mem_addr_sel_o,
  output logic           mem_wr_o
);
  uword_t        uw;
  logic          inc;
  logic [AW-1:0] car_q;

  useq_rom u_rom (
    .addr_i (car_q),
    .word_o (uw)
  );

  useq_cond u_cond (
    .sel_i   (uw.ms),
    .flags_i (flags_i),
    .inc_o   (inc)
  );

  useq_car u_car (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .inc_i      (inc),
    .load_sel_i (uw.mc),
    .nxt_i      (uw.nxt),
    .opcode_i   (opcode_i),
    .car_o      (car_q)
  );

  assign car_o          = car_q;
  assign next_addr_o    = uw.nxt;
  assign cond_sel_o     = uw.ms;
  assign load_sel_o     = uw.mc;
  assign ir_load_o      = uw.il;
  assign pc_inc_o       = uw.pi;
  assign pc_load_o      = uw.pl;
  assign tmp_dst_o      = uw.td;
  assign tmp_a_o        = uw.ta;
  assign tmp_b_o        = uw.tb;
  assign imm_sel_o      = uw.mb;
  assign fn_sel_o       = uw.fs;
  assign mem_data_sel_o = uw.md;
  assign reg_wr_o       = uw.rw;
  assign mem_addr_sel_o = uw.mm;
  assign mem_wr_o       = uw.mw;
endmodule

// File: rtl/useq_ctrl_chk.sv
module useq_ctrl_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic [6:0]  opcode_i,
  input logic [3:0]  flags_i,
  input logic [7:0]  car_o,
  input logic [7:0]  next_addr_o,
  input logic [2:0]  cond_sel_o,
  input logic        load_sel_o,
  input logic [15:0] ctl_w
);
  logic cond_c;
  always_comb begin
    case (cond_sel_o)
      3'd0:    cond_c = 1'b0;
      3'd1:    cond_c = 1'b1;
      3'd2:    cond_c = flags_i[0];
      3'd3:    cond_c = flags_i[1];
      3'd4:    cond_c = flags_i[2];
      3'd5:    cond_c = flags_i[3];
      3'd6:    cond_c = !flags_i[1];
      default: cond_c = !flags_i[0];
    endcase
  end

  AST_RST_CAR_ZERO: assert property (@(posedge clk_i) !rst_ni |-> car_o == 8'd0); // R1
  AST_ALWAYS_STEPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cond_sel_o == 3'd1 |=> car_o == $past(car_o) + 8'd1); // R4
  AST_STEP_ON_COND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cond_c |=> car_o == $past(car_o) + 8'd1); // R5
  AST_LOAD_NEXT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cond_c && !load_sel_o) |=> car_o == $past(next_addr_o)); // R6
  AST_LOAD_OPCODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cond_c && load_sel_o) |=> car_o == {1'b0, $past(opcode_i)}); // R7
  AST_CTL_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $stable(car_o) |-> ($stable(ctl_w) && $stable(next_addr_o) && $stable(cond_sel_o)
                        && $stable(load_sel_o))); // R8
endmodule

bind useq_ctrl useq_ctrl_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .opcode_i    (opcode_i),
  .flags_i     (flags_i),
  .car_o       (car_o),
  .next_addr_o (next_addr_o),
  .cond_sel_o  (cond_sel_o),
  .load_sel_o  (load_sel_o),
  .ctl_w       ({ir_load_o, pc_inc_o, pc_load_o, tmp_dst_o, tmp_a_o, tmp_b_o, imm_sel_o,
                 fn_sel_o, mem_data_sel_o, reg_wr_o, mem_addr_sel_o, mem_wr_o})
);

// File: tb/useq_ctrl_tb.sv
module useq_ctrl_tb;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic [6:0] opcode = '0;
  logic [3:0] flags = '0;
  logic [7:0] car_o, next_addr_o;
  logic [2:0] cond_sel_o;
  logic       load_sel_o, ir_load_o, pc_inc_o, pc_load_o, tmp_dst_o, tmp_a_o, tmp_b_o;
  logic       imm_sel_o, mem_data_sel_o, reg_wr_o, mem_addr_sel_o, mem_wr_o;
  logic [4:0] fn_sel_o;

  always #(CLK_PERIOD/2) clk = ~clk;

  useq_ctrl u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .opcode_i(opcode), .flags_i(flags),
    .car_o(car_o), .next_addr_o(next_addr_o), .cond_sel_o(cond_sel_o),
    .load_sel_o(load_sel_o), .ir_load_o(ir_load_o), .pc_inc_o(pc_inc_o),
    .pc_load_o(pc_load_o), .tmp_dst_o(tmp_dst_o), .tmp_a_o(tmp_a_o), .tmp_b_o(tmp_b_o),
    .imm_sel_o(imm_sel_o), .fn_sel_o(fn_sel_o), .mem_data_sel_o(mem_data_sel_o),
    .reg_wr_o(reg_wr_o), .mem_addr_sel_o(mem_addr_sel_o), .mem_wr_o(mem_wr_o)
  );

  wire [27:0] out_word = {next_addr_o, cond_sel_o, load_sel_o, ir_load_o, pc_inc_o,
                          pc_load_o, tmp_dst_o, tmp_a_o, tmp_b_o, imm_sel_o, fn_sel_o,
                          mem_data_sel_o, reg_wr_o, mem_addr_sel_o, mem_wr_o};

  int checks = 0;
  int errors = 0;
  logic [7:0]  car_m = '0;
  logic [15:0] lfsr = 16'hACE1;
  logic [15:0] cov = '0;

  // R2 table contents
  function automatic logic [27:0] exp_word(input logic [7:0] a);
    return {a + 8'd37, a[2:0], a[3], a, ~a};
  endfunction

  // R4 condition encoding
  function automatic logic cond_true(input logic [2:0] ms, input logic [3:0] f);
    case (ms)
      3'd0: return 1'b0;
      3'd1: return 1'b1;
      3'd2: return f[0];
      3'd3: return f[1];
      3'd4: return f[2];
      3'd5: return f[3];
      3'd6: return !f[1];
      default: return !f[0];
    endcase
  endfunction

  function automatic logic [3:0] flags_for(input logic [2:0] ms, input logic want,
                                           input logic [3:0] fill);
    logic [3:0] f = fill;
    case (ms)
      3'd2: f[0] = want;
      3'd3: f[1] = want;
      3'd4: f[2] = want;
      3'd5: f[3] = want;
      3'd6: f[1] = !want;
      3'd7: f[0] = !want;
      default: ;
    endcase
    return f;
  endfunction

  task automatic bump();
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // one clock: inputs set at negedge, result sampled at the following negedge
  task automatic step(input logic [3:0] f, input logic [6:0] op);
    logic [27:0] w = exp_word(car_m);
    logic [7:0]  nxt;
    string       tag;
    logic        c = cond_true(w[19:17], f);
    flags = f;
    opcode = op;
    cov[{w[19:17], c}] = 1'b1;
    if (c)          begin nxt = car_m + 8'd1;  tag = "R5 step";        end
    else if (w[16]) begin nxt = {1'b0, op};    tag = "R7 opcode load"; end
    else            begin nxt = w[27:20];      tag = "R6 next load";   end
    @(posedge clk);
    @(negedge clk);
    car_m = nxt;
    check(tag, car_o, car_m);
    check("R3 decode", out_word, exp_word(car_m));
  endtask

  task automatic t_reset();
    @(negedge clk);
    check("R1 reset car", car_o, 8'd0);
    check("R2 word 0", out_word, 28'h250_00FF);
    rst_ni = 1'b1;
    car_m = '0;
    step(4'hF, 7'h11);  // never-step at 0, load next
    check("R4 never", car_o, 8'd37);
  endtask

  task automatic t_cond_cover();
    for (int i = 0; i < 600 && cov != 16'hFFF9; i++) begin
      bump();
      step(flags_for(exp_word(car_m)[19:17], lfsr[4], lfsr[3:0]), lfsr[11:5]);
    end
    check("R4 all encodings", cov, 16'hFFF9);
  endtask

  task automatic t_opcode_load();
    for (int i = 0; i < 300; i++) begin
      logic [27:0] w = exp_word(car_m);
      if (w[16] && w[19:17] != 3'd1) break;
      bump();
      step(lfsr[3:0], lfsr[10:4]);
    end
    begin
      logic [2:0] ms = exp_word(car_m)[19:17];
      step(flags_for(ms, 1'b0, lfsr[3:0]), 7'h7F);
      check("R7 zero-extend", car_o, 8'h7F);
    end
  endtask

  task automatic t_priority();
    for (int i = 0; i < 300; i++) begin
      logic [27:0] w = exp_word(car_m);
      if (w[16] && w[19:17] >= 3'd2 && car_m + 8'd1 != 8'h55) break;
      bump();
      step(lfsr[3:0], lfsr[10:4]);
    end
    begin
      logic [7:0] prev = car_m;
      logic [2:0] ms = exp_word(car_m)[19:17];
      step(flags_for(ms, 1'b1, lfsr[3:0]), 7'h55);
      check("R5 step beats opcode", car_o, prev + 8'd1);
    end
  endtask

  task automatic t_flag_isolation();
    logic [27:0] w0 = out_word;
    logic [7:0]  c0 = car_o;
    for (int f = 0; f < 16; f++) begin
      flags = 4'(f);
      opcode = 7'(f * 9);
      #0.2;
      check("R8 flags ignored", out_word, w0);
    end
    check("R8 car held", car_o, c0);
  endtask

  task automatic t_async_reset();
    @(negedge clk);
    #1 rst_ni = 1'b0;
    #1;
    check("R1 async clear", car_o, 8'd0);
    check("R3 decode at 0", out_word, exp_word(8'd0));
    @(negedge clk);
    rst_ni = 1'b1;
    car_m = '0;
    step(4'h0, 7'h00);
    check("R6 after reset", car_o, 8'd37);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_flag_isolation();
    t_cond_cover();
    t_opcode_load();
    t_flag_isolation();
    t_priority();
    t_async_reset();
    for (int i = 0; i < 50; i++) begin
      bump();
      step(lfsr[3:0], lfsr[12:6]);
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule